// File: doc/BRIEF.md
# Standby Bus Wake-Up Filter

This block watches a CAN bus while the node is in its low-power standby state and decides whether a wake-up should be reported. Its input is the digital output of a low-power differential comparator: 1 means dominant and 0 means recessive. The block qualifies that level with a persistence filter. A bus level is accepted only after it has been sampled unchanged for a set number of clock cycles. The accepted level is then shown, inverted, on the receive-data output: low means a wake-up request is seen, and high means none.

The filter does not latch. The output follows the accepted bus level in both directions. A second counter times how long the accepted level stays dominant. If the dominant phase runs past a time-out, the block forces the output high and raises a stuck flag. A bus that is clamped dominant therefore cannot hold a wake-up request for ever.

When the standby qualifier is low, all state returns to recessive on the next clock edge. Both lengths are parameters given in clock cycles. The defaults are 1 µs and 2 ms at 250 MHz.

Top module: `wkf_wake_filter`

## Requirements
- R1: After a synchronous active-low reset, `rxd_o` is 1 and `bus_stuck_o` is 0.
- R2: In standby, `bus_dom_i` = 1 sampled on FILT_CYC consecutive rising edges drives `rxd_o` to 0 right after the last of those edges. `rxd_o` = 0 means wake-up requested; `rxd_o` = 1 means none.
- R3: A dominant run shorter than FILT_CYC samples leaves `rxd_o` at 1.
- R4: The filter does not latch. FILT_CYC consecutive recessive samples after an accepted dominant level bring `rxd_o` back to 1. Recessive gaps shorter than FILT_CYC samples leave `rxd_o` at 0.
- R5: Once the accepted level has been dominant for TMO_CYC clock cycles, `bus_stuck_o` goes to 1 and `rxd_o` is forced to 1. As a result, `rxd_o` is never low for more than TMO_CYC consecutive cycles.
- R6: The dominant timer restarts from zero for each new accepted dominant phase. A fresh phase gets the full TMO_CYC cycles of `rxd_o` = 0.
- R7: After a time-out, `rxd_o` stays 1 and `bus_stuck_o` stays 1 until the accepted level returns to recessive, which takes FILT_CYC recessive samples. `bus_stuck_o` clears one cycle after that.
- R8: While `stby_en_i` is 0, the next edge sets `rxd_o` to 1 and `bus_stuck_o` to 0 and clears both counters. `bus_dom_i` has no effect during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stby_en_i | input | 1 | 1 while standby monitoring is active |
| bus_dom_i | input | 1 | Low-power comparator output, 1 = dominant |
| rxd_o | output | 1 | Filtered wake indication, 0 = wake-up requested |
| bus_stuck_o | output | 1 | 1 after a bus-dominant time-out, until the bus recovers |

## Verification
A persistence counter that is off by one shows up directly at `rxd_o`. The output edge moves one cycle early or late, or a glitch one sample shorter than FILT_CYC gets through, and this is visible within FILT_CYC cycles of the bus change. A dominant timer that does not restart, or a stuck flag that does not clear, shows up on the next dominant phase. In that phase the low pulse on `rxd_o` is shorter than TMO_CYC, or `rxd_o` never drops at all. A missing standby clear shows one cycle after `stby_en_i` falls, as `rxd_o` low or `bus_stuck_o` high.

// File: rtl/wkf_pkg.sv
// Package: shared types for the standby wake-up filter.
// Assumes: single-bit bus level, 1 = dominant.
package wkf_pkg;
    typedef enum logic {
        LVL_REC = 1'b0,
        LVL_DOM = 1'b1
    } bus_lvl_e;
endpackage

// File: rtl/wkf_persist_filter.sv
// Module: persistence filter. A raw level that differs from the accepted
// level must be sampled FILT_CYC times in a row before it becomes the new
// accepted level. Any sample equal to the accepted level restarts the count.
// Assumes: raw_i is already synchronous to clk, and FILT_CYC >= 2.
module wkf_persist_filter
    import wkf_pkg::*;
#(
    parameter int FILT_CYC = 250
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr_i,
    input  bus_lvl_e raw_i,
    output bus_lvl_e lvl_o
);
    localparam int FW = $clog2(FILT_CYC + 1);
    localparam logic [FW-1:0] LAST = FW'(FILT_CYC - 1);

    bus_lvl_e      lvl_q;
    logic [FW-1:0] run_q;

    // Count the differing samples and flip the accepted level on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            lvl_q <= LVL_REC;
            run_q <= '0;
        end else if (raw_i != lvl_q) begin
            if (run_q == LAST) begin
                lvl_q <= raw_i;
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    assign lvl_o = lvl_q;
endmodule

// File: rtl/wkf_dom_timeout.sv
// Module: dominant time-out. Counts the cycles in which the accepted level
// is dominant. Sets stuck after TMO_CYC such cycles. Clears stuck and the
// count on the first cycle in which the accepted level is recessive.
// Assumes: TMO_CYC >= 2; dom_i comes straight from the filter register.
module wkf_dom_timeout #(
    parameter int TMO_CYC = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic dom_i,
    output logic stuck_o
);
    localparam int TW = $clog2(TMO_CYC + 1);
    localparam logic [TW-1:0] LAST = TW'(TMO_CYC - 1);

    logic [TW-1:0] age_q;
    logic          stuck_q;

    // Age the dominant phase and raise stuck when it reaches the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || !dom_i) begin
            age_q   <= '0;
            stuck_q <= 1'b0;
        end else if (!stuck_q) begin
            if (age_q == LAST) begin
                stuck_q <= 1'b1;
                age_q   <= '0;
            end else begin
                age_q <= age_q + 1'b1;
            end
        end
    end

    assign stuck_o = stuck_q;
endmodule

// File: rtl/wkf_wake_filter.sv
// Module: top of the standby wake-up filter. The persistence filter feeds
// the dominant time-out. rxd_o is low only while the accepted level is
// dominant and no time-out has happened.
// Assumes: bus_dom_i is synchronous to clk. Leaving standby clears all state.
module wkf_wake_filter
    import wkf_pkg::*;
#(
    parameter int FILT_CYC = 250,
    parameter int TMO_CYC  = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stby_en_i,
    input  logic bus_dom_i,
    output logic rxd_o,
    output logic bus_stuck_o
);
    bus_lvl_e raw_lvl;
    bus_lvl_e acc_lvl;
    logic     clr;
    logic     stuck;

    // Map the comparator bit onto the level type and derive the clear.
    always_comb begin
        raw_lvl = bus_dom_i ? LVL_DOM : LVL_REC;
        clr     = !stby_en_i;
    end

    wkf_persist_filter #(.FILT_CYC(FILT_CYC)) filt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .raw_i (raw_lvl),
        .lvl_o (acc_lvl)
    );

    wkf_dom_timeout #(.TMO_CYC(TMO_CYC)) tmo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .dom_i   (acc_lvl == LVL_DOM),
        .stuck_o (stuck)
    );

    // Drive the active-low wake indication and the stuck flag.
    always_comb begin
        rxd_o       = !((acc_lvl == LVL_DOM) && !stuck);
        bus_stuck_o = stuck;
    end
endmodule

// File: rtl/wkf_wake_filter_chk.sv
// Module: port-level checker for wkf_wake_filter, attached with bind.
// Assumes: FILT_CYC >= 2, so two samples of history are always enough.
module wkf_wake_filter_chk #(
    parameter int FILT_CYC = 250,
    parameter int TMO_CYC  = 500000
) (
    input logic clk,
    input logic rst_n,
    input logic stby_en_i,
    input logic bus_dom_i,
    input logic rxd_o,
    input logic bus_stuck_o
);
    localparam int LW = $clog2(TMO_CYC + 2);
    logic [LW-1:0] low_len_q;

    // Measure the current run of low cycles on rxd_o, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || rxd_o) low_len_q <= '0;
        else if (low_len_q != LW'(TMO_CYC + 1)) low_len_q <= low_len_q + 1'b1;
    end

    assert_stby_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !stby_en_i |=> (rxd_o && !bus_stuck_o));

    assert_fall_needs_dom_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rxd_o) |-> ($past(bus_dom_i) && $past(stby_en_i)));

    assert_rise_needs_rec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rxd_o) && !bus_stuck_o && $past(stby_en_i)) |-> !$past(bus_dom_i));

    assert_low_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        low_len_q <= LW'(TMO_CYC));

    assert_stuck_from_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_stuck_o) |-> ($past(!rxd_o) && rxd_o));
endmodule

bind wkf_wake_filter wkf_wake_filter_chk #(
    .FILT_CYC(FILT_CYC),
    .TMO_CYC (TMO_CYC)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stby_en_i  (stby_en_i),
    .bus_dom_i  (bus_dom_i),
    .rxd_o      (rxd_o),
    .bus_stuck_o(bus_stuck_o)
);

// File: tb/wkf_wake_filter_tb_top.sv
// Bench: directed corner cases, then seeded random bursts. Every cycle is
// compared with a run-length model written from the requirements.
module wkf_wake_filter_tb_top;
    localparam int FILT = 5;
    localparam int TMO  = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stby = 1'b0;
    logic bus = 1'b0;
    logic rxd;
    logic stuck;

    int n_vec = 0;
    int n_bad = 0;
    string cur_req = "R1";

    // Model state.
    bit m_dom = 0;
    bit m_stuck = 0;
    bit run_val = 0;
    int run_len = 0;
    int dom_len = 0;

    always #2 clk = ~clk;

    wkf_wake_filter #(.FILT_CYC(FILT), .TMO_CYC(TMO)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .stby_en_i  (stby),
        .bus_dom_i  (bus),
        .rxd_o      (rxd),
        .bus_stuck_o(stuck)
    );

    function automatic bit exp_rxd();
        return !(m_dom && !m_stuck);
    endfunction

    // Advance the model by one sampled edge.
    task automatic model_edge(input bit r, input bit s, input bit d);
        bit nd;
        if (!r || !s) begin
            m_dom = 0; m_stuck = 0; run_val = 0; run_len = 0; dom_len = 0;
        end else begin
            if (d == run_val) run_len++;
            else begin run_val = d; run_len = 1; end
            nd = m_dom;
            if (d != m_dom && run_len >= FILT) nd = d;
            if (!m_dom) begin m_stuck = 0; dom_len = 0; end
            else if (!m_stuck) begin
                dom_len++;
                if (dom_len == TMO) m_stuck = 1;
            end
            m_dom = nd;
        end
    endtask

    task automatic check(input string req, input bit act, input bit exp, input string what);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input bit s, input bit d);
        @(negedge clk);
        stby = s; bus = d;
        @(posedge clk);
        model_edge(rst_n, s, d);
        #1;
        check(cur_req, rxd, exp_rxd(), "rxd_o");
        check(cur_req, stuck, m_stuck, "bus_stuck_o");
    endtask

    task automatic hold(input bit s, input bit d, input int n);
        for (int i = 0; i < n; i++) step(s, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        // R1: reset state.
        cur_req = "R1";
        rst_n = 1'b0;
        hold(1, 1, 3);
        rst_n = 1'b1;
        hold(1, 0, 3);
        // R3: glitch of FILT-1 samples is ignored.
        cur_req = "R3";
        hold(1, 1, FILT - 1);
        hold(1, 0, 3);
        check("R3", rxd, 1'b1, "rxd_o after short glitch");
        // R2: exactly FILT samples are accepted.
        cur_req = "R2";
        hold(1, 1, FILT - 1);
        check("R2", rxd, 1'b1, "rxd_o one sample early");
        step(1, 1);
        check("R2", rxd, 1'b0, "rxd_o at FILT samples");
        // R4: short recessive gap ignored, full one releases.
        cur_req = "R4";
        hold(1, 0, FILT - 1);
        hold(1, 1, 2);
        check("R4", rxd, 1'b0, "rxd_o after short gap");
        hold(1, 0, FILT);
        check("R4", rxd, 1'b1, "rxd_o after full recessive");
        // R5: time-out forces rxd high.
        cur_req = "R5";
        hold(1, 1, FILT + TMO + 4);
        check("R5", stuck, 1'b1, "bus_stuck_o after timeout");
        check("R5", rxd, 1'b1, "rxd_o after timeout");
        // R7: stays stuck through a short gap, recovers after full recessive.
        cur_req = "R7";
        hold(1, 0, FILT - 1);
        hold(1, 1, 1);
        check("R7", stuck, 1'b1, "bus_stuck_o through short gap");
        hold(1, 0, FILT + 1);
        check("R7", stuck, 1'b0, "bus_stuck_o after recovery");
        // R6: fresh dominant phase gets a full window.
        cur_req = "R6";
        hold(1, 1, FILT + TMO - 1);
        check("R6", rxd, 1'b0, "rxd_o still low before new timeout");
        step(1, 1);
        check("R6", rxd, 1'b1, "rxd_o at new timeout");
        hold(1, 0, FILT + 2);
        // R8: dropping standby clears, bus ignored.
        cur_req = "R8";
        hold(1, 1, FILT + 2);
        step(0, 1);
        check("R8", rxd, 1'b1, "rxd_o after standby drop");
        hold(0, 1, FILT + TMO);
        check("R8", stuck, 1'b0, "bus_stuck_o outside standby");
        hold(1, 1, FILT - 1);
        check("R8", rxd, 1'b1, "rxd_o count restarted on re-entry");
        // Random bursts checked against the model (R2 R4 R5 R8).
        cur_req = "RND";
        for (int b = 0; b < 120; b++) begin
            bit lv = 1'($urandom % 2);
            bit sb = ($urandom % 10) != 0;
            int len = 1 + int'($urandom % (2 * FILT + 2));
            if ($urandom % 8 == 0) begin lv = 1; len = TMO + FILT + 3; end
            hold(sb, lv, len);
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule